// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Bank

This block records when signal edges occur. It has one free-running time counter. The counter advances once per coarse tick, and the tick comes from dividing the system clock. Twelve independent capture units share that counter. Each unit watches one source, picked by index from a combined vector. The low indices are asynchronous pin inputs and the high indices are internal event lines that are already in the clock domain. Each unit reacts to the edge polarity that is programmed for it.

When a unit's programmed edge appears and the unit is enabled, the unit does three things:
- it copies the current counter value into its own capture register;
- it raises its interrupt line, which stays high until software clears it;
- if its interrupt was already pending, it marks an overrun, and that mark stays set until the clear.

Software picks a unit on a small read port. It reads back that unit's overrun mark and captured time, and it can clear the unit's interrupt and overrun with a one-cycle strobe.

Top module: `ts_capture_bank`

## Requirements
- R1: While reset is asserted and right after it is released, the time counter reads 0, every interrupt line is low, and every capture register and overrun flag is 0.
- R2: The time counter increments by exactly 1 once every TICK_DIV clock cycles (15 by default, which is 75 ns at 200 MHz). It wraps modulo 2^TIME_W (TIME_W is 31 by default) and never stalls.
- R3: The source select index of each unit maps values 0 to NUM_PINS-1 onto the pin inputs and the next NUM_EVENTS values onto the event inputs. Any other index selects no source. A unit reacts only to the source it selects.
- R4: The edge mode of each unit is a 2-bit field: 2'b01 captures on rising edges, 2'b10 on falling edges, 2'b11 on both edges, and 2'b00 never captures.
- R5: A pin change driven before clock edge k is captured at edge k+2, after a two-flop synchronizer and an edge stage. An event change is captured at edge k+1. The stored value is the counter value just before that capture edge.
- R6: A capture sets the unit's interrupt line. The line stays high until the unit is cleared.
- R7: A capture that arrives while the unit's interrupt is still high overwrites the capture register and sets the unit's sticky overrun flag.
- R8: A clear strobe, with rd_sel naming a unit, drops that unit's interrupt and overrun flag in the next cycle. It leaves the captured value and all other units unchanged.
- R9: A disabled unit ignores edges on its source. It keeps its last captured value, and its interrupt stays as it was.
- R10: rd_data is combinational. It is {overrun, capture value} of the unit named by rd_sel, and 0 for an index past the last unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| evt_i | input | NUM_EVENTS | Internal event lines, synchronous to clk |
| cfg_en | input | NUM_UNITS | Per-unit enable |
| cfg_sel | input | NUM_UNITS*SEL_W | Per-unit source index, unit u in bits [u*SEL_W +: SEL_W] |
| cfg_mode | input | NUM_UNITS*2 | Per-unit edge mode, unit u in bits [u*2 +: 2] |
| time_o | output | TIME_W | Current time counter value |
| cap_value | output | NUM_UNITS*TIME_W | Per-unit captured time, unit u in bits [u*TIME_W +: TIME_W] |
| irq | output | NUM_UNITS | Per-unit level interrupt |
| rd_sel | input | IDX_W | Unit index for read and clear |
| clr_i | input | 1 | Clear strobe for the unit named by rd_sel |
| rd_data | output | TIME_W+1 | {overrun, captured time} of the selected unit |

## Verification
The capture path is driven with four patterns:
- Rising, falling and both-edge modes on separate pins, which tells the polarity decode of each mode apart from the others.
- An edge on a neighbouring pin that a different unit watches, which separates correct source selection from a shared trigger.
- Event-line edges next to pin edges, which shows the one-cycle difference in latency between synchronized and already-synchronous sources.
- Back-to-back captures without a clear, and an edge on a disabled unit, which tell overwrite-with-overrun apart from hold-and-ignore.

Every captured value is compared with the counter value seen on time_o in the cycle before the capture edge. A wrong latency therefore shows up as a value that is off by one tick.

// File: rtl/ts_pkg.sv
`timescale 1ns/1ps
package ts_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/ts_timebase.sv
`timescale 1ns/1ps
module ts_timebase #(
  parameter int TIME_W   = 31,
  parameter int TICK_DIV = 15,
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick_o,
  output logic [TIME_W-1:0] time_o
);
  logic [DIV_W-1:0]  pre_q, pre_d;
  logic [TIME_W-1:0] t_q, t_d;
  logic              tick;

  assign tick = (pre_q == DIV_W'(TICK_DIV - 1));

  always_comb begin
    pre_d = tick ? '0 : pre_q + 1'b1;
    t_d   = tick ? t_q + 1'b1 : t_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      t_q   <= '0;
    end else begin
      pre_q <= pre_d;
      t_q   <= t_d;
    end
  end

  assign tick_o = tick;
  assign time_o = t_q;
endmodule

// File: rtl/ts_src_front.sv
`timescale 1ns/1ps
module ts_src_front #(
  parameter int NUM_PINS   = 16,
  parameter int NUM_EVENTS = 8,
  localparam int NUM_SRC   = NUM_PINS + NUM_EVENTS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [NUM_EVENTS-1:0] evt_i,
  output logic [NUM_SRC-1:0]    rise_o,
  output logic [NUM_SRC-1:0]    fall_o
);
  logic [NUM_PINS-1:0]   meta_q, sync_q;
  logic [NUM_EVENTS-1:0] evt_q;
  logic [NUM_SRC-1:0]    cur, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      evt_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      evt_q  <= evt_i;
      prev_q <= cur;
    end
  end

  assign cur    = {evt_q, sync_q};
  assign rise_o = cur & ~prev_q;
  assign fall_o = ~cur & prev_q;
endmodule

// File: rtl/ts_unit.sv
`timescale 1ns/1ps
module ts_unit
  import ts_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int TIME_W  = 31,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        mode_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] fall_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              clr_i,
  output logic [TIME_W-1:0] cap_o,
  output logic              irq_o,
  output logic              ovr_o
);
  logic [TIME_W-1:0] cap_q, cap_d;
  logic              irq_q, irq_d, ovr_q, ovr_d;
  logic              sel_ok, r_hit, f_hit, hit, trig;

  always_comb begin
    sel_ok = (32'(sel_i) < NUM_SRC);
    r_hit  = sel_ok && rise_i[sel_i];
    f_hit  = sel_ok && fall_i[sel_i];
    unique case (edge_mode_e'(mode_i))
      EDGE_RISE: hit = r_hit;
      EDGE_FALL: hit = f_hit;
      EDGE_ANY:  hit = r_hit | f_hit;
      default:   hit = 1'b0;
    endcase
    trig = en_i && hit;
  end

  always_comb begin
    cap_d = cap_q;
    irq_d = irq_q;
    ovr_d = ovr_q;
    if (clr_i) begin
      irq_d = 1'b0;
      ovr_d = 1'b0;
    end
    if (trig) begin
      cap_d = time_i;
      irq_d = 1'b1;
      ovr_d = (irq_q && !clr_i) || (ovr_q && !clr_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (trig) cap_q <= cap_d;
      irq_q <= irq_d;
      ovr_q <= ovr_d;
    end
  end

  assign cap_o = cap_q;
  assign irq_o = irq_q;
  assign ovr_o = ovr_q;
endmodule

// File: rtl/ts_capture_bank.sv
`timescale 1ns/1ps
module ts_capture_bank #(
  parameter int NUM_UNITS  = 12,
  parameter int NUM_PINS   = 16,
  parameter int NUM_EVENTS = 8,
  parameter int TIME_W     = 31,
  parameter int TICK_DIV   = 15,
  localparam int NUM_SRC   = NUM_PINS + NUM_EVENTS,
  localparam int SEL_W     = $clog2(NUM_SRC),
  localparam int IDX_W     = $clog2(NUM_UNITS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PINS-1:0]           pin_i,
  input  logic [NUM_EVENTS-1:0]         evt_i,
  input  logic [NUM_UNITS-1:0]          cfg_en,
  input  logic [NUM_UNITS*SEL_W-1:0]    cfg_sel,
  input  logic [NUM_UNITS*2-1:0]        cfg_mode,
  output logic [TIME_W-1:0]             time_o,
  output logic [NUM_UNITS*TIME_W-1:0]   cap_value,
  output logic [NUM_UNITS-1:0]          irq,
  input  logic [IDX_W-1:0]              rd_sel,
  input  logic                          clr_i,
  output logic [TIME_W:0]               rd_data
);
  logic [1:0]            rst_sync_q;
  logic                  rst_sync_n;
  logic                  tick;
  logic [NUM_SRC-1:0]    rise_v, fall_v;
  logic [NUM_UNITS-1:0]  ovr_v;
  logic [NUM_UNITS-1:0]  clr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ts_timebase #(.TIME_W(TIME_W), .TICK_DIV(TICK_DIV)) u_tb (
    .clk(clk), .rst_n(rst_sync_n), .tick_o(tick), .time_o(time_o)
  );

  ts_src_front #(.NUM_PINS(NUM_PINS), .NUM_EVENTS(NUM_EVENTS)) u_front (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(pin_i), .evt_i(evt_i),
    .rise_o(rise_v), .fall_o(fall_v)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign clr_v[u] = clr_i && (32'(rd_sel) == u);
    ts_unit #(.NUM_SRC(NUM_SRC), .TIME_W(TIME_W)) u_cap (
      .clk(clk), .rst_n(rst_sync_n),
      .en_i(cfg_en[u]),
      .sel_i(cfg_sel[u*SEL_W +: SEL_W]),
      .mode_i(cfg_mode[u*2 +: 2]),
      .rise_i(rise_v), .fall_i(fall_v),
      .time_i(time_o),
      .clr_i(clr_v[u]),
      .cap_o(cap_value[u*TIME_W +: TIME_W]),
      .irq_o(irq[u]),
      .ovr_o(ovr_v[u])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (32'(rd_sel) == u) rd_data = {ovr_v[u], cap_value[u*TIME_W +: TIME_W]};
    end
  end

  logic unused_tick;
  assign unused_tick = tick;
endmodule

// File: rtl/ts_capture_bank_chk.sv
`timescale 1ns/1ps
module ts_capture_bank_chk #(
  parameter int NUM_UNITS = 12,
  parameter int TIME_W    = 31,
  parameter int IDX_W     = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_UNITS-1:0]        cfg_en,
  input logic [TIME_W-1:0]           time_o,
  input logic [NUM_UNITS*TIME_W-1:0] cap_value,
  input logic [NUM_UNITS-1:0]        irq,
  input logic [NUM_UNITS-1:0]        ovr,
  input logic [IDX_W-1:0]            rd_sel,
  input logic                        clr_i
);
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(time_o) |-> time_o == TIME_W'($past(time_o) + 1'b1)); // R2

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    AST_OVR_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ovr[u] |-> irq[u]); // R7

    AST_CAP_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_value[u*TIME_W +: TIME_W]) |-> irq[u]); // R6

    AST_IRQ_DROP_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[u]) |-> $past(clr_i && (32'(rd_sel) == u))); // R8

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cfg_en[u]) |-> $stable(cap_value[u*TIME_W +: TIME_W])); // R9
  end
endmodule

bind ts_capture_bank ts_capture_bank_chk #(
  .NUM_UNITS(NUM_UNITS), .TIME_W(TIME_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cfg_en(cfg_en), .time_o(time_o),
  .cap_value(cap_value), .irq(irq), .ovr(ovr_v), .rd_sel(rd_sel), .clr_i(clr_i)
);

// File: tb/tb_ts_capture_bank.sv
`timescale 1ns/1ps
module tb_ts_capture_bank;
  localparam int NU = 12, NP = 16, NE = 8, TW = 31, SW = 5, IW = 4;

  logic             clk;
  logic             rst_n;
  logic [NP-1:0]    pin_i;
  logic [NE-1:0]    evt_i;
  logic [NU-1:0]    cfg_en;
  logic [NU*SW-1:0] cfg_sel;
  logic [NU*2-1:0]  cfg_mode;
  logic [TW-1:0]    time_o;
  logic [NU*TW-1:0] cap_value;
  logic [NU-1:0]    irq;
  logic [IW-1:0]    rd_sel;
  logic             clr_i;
  logic [TW:0]      rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  ts_capture_bank dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .evt_i(evt_i),
    .cfg_en(cfg_en), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode),
    .time_o(time_o), .cap_value(cap_value), .irq(irq),
    .rd_sel(rd_sel), .clr_i(clr_i), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] cap_of(input int u);
    return cap_value[u*TW +: TW];
  endfunction

  task automatic cfg(input int u, input bit en, input int sel, input logic [1:0] mode);
    @(negedge clk);
    cfg_en[u]            = en;
    cfg_sel[u*SW +: SW]  = SW'(sel);
    cfg_mode[u*2 +: 2]   = mode;
  endtask

  // Drive one source level and return the counter value the capture must hold.
  task automatic drive_src(input bit is_evt, input int idx, input bit lvl,
                           output logic [TW-1:0] exp_t);
    @(negedge clk);
    if (is_evt) evt_i[idx] = lvl; else pin_i[idx] = lvl;
    @(posedge clk);
    if (!is_evt) @(posedge clk);
    @(negedge clk);
    exp_t = time_o;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_unit(input int u);
    @(negedge clk);
    rd_sel = IW'(u);
    clr_i  = 1'b1;
    @(negedge clk);
    clr_i  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 time in reset", time_o, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 time after release", time_o, 0);
    chk("R1 captures zero", cap_value[63:0], 0);
    rd_sel = 4'd0;
    #0.1;
    chk("R1 R10 rd_data zero", rd_data, 0);
  endtask

  task automatic t_timebase;
    logic [TW-1:0] t0;
    @(negedge clk);
    t0 = time_o;
    idle(150);
    chk("R2 ten ticks in 150 cycles", time_o - t0, 10);
  endtask

  task automatic t_rise;
    logic [TW-1:0] e, dummy;
    cfg(0, 1, 3, 2'b01);
    cfg(1, 1, 4, 2'b01);
    drive_src(0, 3, 1, e);
    chk("R5 pin rise capture", cap_of(0), e);
    chk("R6 irq raised", irq[0], 1);
    chk("R3 other unit quiet", irq[1], 0);
    rd_sel = 4'd0;
    #0.1;
    chk("R10 rd_data", rd_data, {1'b0, e});
    idle(20);
    drive_src(0, 3, 0, dummy);
    chk("R4 fall ignored in rise mode", cap_of(0), e);
    clear_unit(0);
    chk("R8 irq cleared", irq[0], 0);
    chk("R8 value kept", cap_of(0), e);
  endtask

  task automatic t_fall;
    logic [TW-1:0] e;
    cfg(2, 1, 5, 2'b10);
    drive_src(0, 5, 1, e);
    chk("R4 rise ignored in fall mode", irq[2], 0);
    idle(10);
    drive_src(0, 5, 0, e);
    chk("R4 fall capture", cap_of(2), e);
    chk("R4 fall irq", irq[2], 1);
  endtask

  task automatic t_both;
    logic [TW-1:0] e1, e2;
    cfg(3, 1, 6, 2'b11);
    drive_src(0, 6, 1, e1);
    chk("R4 both mode rise", cap_of(3), e1);
    clear_unit(3);
    idle(20);
    drive_src(0, 6, 0, e2);
    chk("R4 both mode fall", cap_of(3), e2);
    chk("R4 both irq", irq[3], 1);
  endtask

  task automatic t_off;
    logic [TW-1:0] e;
    cfg(6, 1, 7, 2'b00);
    drive_src(0, 7, 1, e);
    drive_src(0, 7, 0, e);
    chk("R4 mode off no irq", irq[6], 0);
    chk("R4 mode off no capture", cap_of(6), 0);
  endtask

  task automatic t_event;
    logic [TW-1:0] e;
    cfg(4, 1, NP + 2, 2'b01);
    idle(7);
    drive_src(1, 2, 1, e);
    chk("R5 R3 event capture", cap_of(4), e);
    chk("R3 event irq", irq[4], 1);
  endtask

  task automatic t_overrun;
    logic [TW-1:0] e1, e2;
    drive_src(0, 3, 1, e1);
    chk("R7 first capture", cap_of(0), e1);
    drive_src(0, 3, 0, e1);
    idle(20);
    drive_src(0, 3, 1, e2);
    rd_sel = 4'd0;
    #0.1;
    chk("R7 overwrite with overrun", rd_data, {1'b1, e2});
    clear_unit(0);
    #0.1;
    chk("R8 overrun cleared", rd_data, {1'b0, e2});
    chk("R8 irq cleared after overrun", irq[0], 0);
    chk("R8 other units untouched", irq[2], 1);
  endtask

  task automatic t_disable;
    logic [TW-1:0] e, dummy;
    cfg(5, 1, 8, 2'b01);
    drive_src(0, 8, 1, e);
    clear_unit(5);
    cfg(5, 0, 8, 2'b01);
    drive_src(0, 8, 0, dummy);
    idle(20);
    drive_src(0, 8, 1, dummy);
    chk("R9 disabled holds value", cap_of(5), e);
    chk("R9 disabled no irq", irq[5], 0);
  endtask

  task automatic t_rd_range;
    @(negedge clk);
    rd_sel = 4'd13;
    #0.1;
    chk("R10 out of range reads zero", rd_data, 0);
  endtask

  initial begin
    rst_n = 1'b0; pin_i = '0; evt_i = '0; cfg_en = '0;
    cfg_sel = '0; cfg_mode = '0; rd_sel = '0; clr_i = 1'b0;
    idle(4);
    t_reset();
    t_timebase();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_event();
    t_overrun();
    t_disable();
    t_rd_range();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule